// File: doc/BRIEF.md
# SD Card Bus Power-State Sequencer

This block sits on the host side of an SD/MMC card slot and decides how the card clock pin, the command pin and eight data pins are driven. Software sets a two-bit power state through a single 32-bit register on a simple word-addressed bus. Each state has its own pin pattern: released lines after reset, all lines high after an explicit off, and all lines low during a power cycle. In the powered state the card clock runs, the lines idle high for a fixed number of card clock cycles, and then the lines follow the command and data engines.

The same register holds three more fields. The first sets the polarity of the external transceiver's direction signals. The second enables stopping the card clock after a command response during a voltage switch. The third is a free voltage-switch start flag. The first two can only be written under their own conditions. The command engine's enable, a response-received strobe and a per-card-clock tick come in as plain inputs.

Top module: `sd_bus_power_seq`

## Requirements
- R1: After reset the register reads 0. The command and data lines are released (output enables 0). The card clock pin is enabled and driven low, and `clk_run` is 0.
- R2: A word write with bits [1:0] = 00 while not powered gives an off state in which the clock, command and all data pins are enabled and driven high.
- R3: A word write with bits [1:0] = 10 while not powered gives the power-cycle state, in which the clock, command and all data pins are enabled and driven low.
- R4: A word write with bits [1:0] = 01 leaves the state field and the pin pattern unchanged.
- R5: Once the field is 11 it stays 11 until reset, whatever is written.
- R6: After the write that sets 11, `ready` rises only once 74 `cclk_tick` pulses have been seen in cycles after that write. A tick in the same cycle as the write is not counted. Until then, command and data pins are enabled and driven high. In state 11 the clock pin carries `card_clk_src` while `clk_run` is 1.
- R7: Once `ready` is 1, the command and data pins carry the `op_*` inputs.
- R8: Bit 4 (direction polarity) changes only on writes while the field is 00. Each direction output equals its line's output enable when the bit is 1, and the inverse of that enable when the bit is 0.
- R9: Bit 3 (clock stop enable) changes only on writes while `cmd_fsm_en` is 0. When the bit is 1 in state 11, a `resp_ok` pulse stops the card clock (pin low, `clk_run` 0). The clock resumes from the cycle after bit 3 is cleared.
- R10: `bus_size` codes are 00 byte, 01 halfword and 10 word. Any selected access that is not a word raises `bus_err` in that cycle and changes nothing.
- R11: Bits 31 to 5 read as 0 whatever has been written.
- R12: Bit 2 (voltage-switch start) takes every word-written value and drives `vsw_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for a write |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Register contents |
| bus_err | output | 1 | Error response for a non-word access |
| cmd_fsm_en | input | 1 | Command engine enabled |
| resp_ok | input | 1 | Command response received, one-cycle pulse |
| cclk_tick | input | 1 | One pulse per card clock rising edge |
| card_clk_src | input | 1 | Divided card clock |
| op_cmd_oe | input | 1 | Engine command output enable |
| op_cmd_o | input | 1 | Engine command level |
| op_dat_oe | input | 8 | Engine data output enables |
| op_dat_o | input | 8 | Engine data levels |
| clk_oe | output | 1 | Card clock pin enable |
| clk_o | output | 1 | Card clock pin level |
| cmd_oe | output | 1 | Command pin enable |
| cmd_o | output | 1 | Command pin level |
| dat_oe | output | 8 | Data pin enables |
| dat_o | output | 8 | Data pin levels |
| cmd_dir | output | 1 | Transceiver direction for command |
| dat_dir | output | 8 | Transceiver direction per data line |
| clk_run | output | 1 | Card clock running |
| ready | output | 1 | Hold-off complete, normal operation |
| vsw_start | output | 1 | Voltage-switch start flag |

## Verification
Two collisions matter. The first is a card clock tick in the same cycle as the write that sets the powered state. The bench writes 11 with `cclk_tick` high, then gives exactly 73 further ticks and expects `ready` low, then one more and expects it high. The second is a response strobe and the clock stop enable changing together. The bench pulses `resp_ok` in the cycle where a write clears bit 3 and expects the clock to keep running, and it pulses `resp_ok` while `cmd_fsm_en` blocks a clearing write and expects the stop to hold.

// File: rtl/sd_bus_power_seq.sv
module sd_bus_power_seq #(
  parameter int HOLDOFF = 74,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  input  logic          cmd_fsm_en,
  input  logic          resp_ok,
  input  logic          cclk_tick,
  input  logic          card_clk_src,
  input  logic          op_cmd_oe,
  input  logic          op_cmd_o,
  input  logic [DW-1:0] op_dat_oe,
  input  logic [DW-1:0] op_dat_o,
  output logic          clk_oe,
  output logic          clk_o,
  output logic          cmd_oe,
  output logic          cmd_o,
  output logic [DW-1:0] dat_oe,
  output logic [DW-1:0] dat_o,
  output logic          cmd_dir,
  output logic [DW-1:0] dat_dir,
  output logic          clk_run,
  output logic          ready,
  output logic          vsw_start
);
  localparam int CW = $clog2(HOLDOFF + 1);
  localparam logic [1:0] PS_OFF = 2'b00, PS_RSV = 2'b01, PS_CYC = 2'b10, PS_ON = 2'b11;
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [1:0]    ps_q;
  logic          drv_q, go_q, stop_q, pol_q, halt_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, powered, halted;

  assign wr_ok   = bus_sel & bus_wr & (bus_size == SZ_WORD);
  assign bus_err = bus_sel & (bus_size != SZ_WORD);
  assign powered = (ps_q == PS_ON);
  assign halted  = halt_q & stop_q;
  assign ready   = powered & (cnt_q == CW'(HOLDOFF));
  assign clk_run = powered & ~halted;
  assign vsw_start = go_q;
  assign bus_rdata = {27'd0, pol_q, stop_q, go_q, ps_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= PS_OFF;
      drv_q  <= 1'b0;
      go_q   <= 1'b0;
      stop_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (wr_ok) begin
      if (!powered && bus_wdata[1:0] != PS_RSV) begin
        ps_q  <= bus_wdata[1:0];
        drv_q <= (bus_wdata[1:0] == PS_OFF);
      end
      go_q <= bus_wdata[2];
      if (!cmd_fsm_en) stop_q <= bus_wdata[3];
      if (ps_q == PS_OFF) pol_q <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      halt_q <= 1'b0;
    else if (!stop_q)                halt_q <= 1'b0;
    else if (resp_ok && powered)     halt_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (!powered)                        cnt_q <= '0;
    else if (cclk_tick && !ready)             cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    clk_oe = 1'b1;
    clk_o  = 1'b0;
    cmd_oe = 1'b0;
    cmd_o  = 1'b0;
    dat_oe = '0;
    dat_o  = '0;
    unique case (ps_q)
      PS_OFF: if (drv_q) begin
        clk_o  = 1'b1;
        cmd_oe = 1'b1;
        cmd_o  = 1'b1;
        dat_oe = '1;
        dat_o  = '1;
      end
      PS_CYC: begin
        cmd_oe = 1'b1;
        dat_oe = '1;
      end
      PS_ON: begin
        clk_o = card_clk_src & ~halted;
        if (ready) begin
          cmd_oe = op_cmd_oe;
          cmd_o  = op_cmd_o;
          dat_oe = op_dat_oe;
          dat_o  = op_dat_o;
        end else begin
          cmd_oe = 1'b1;
          cmd_o  = 1'b1;
          dat_oe = '1;
          dat_o  = '1;
        end
      end
      default: ;
    endcase
  end

  assign cmd_dir = cmd_oe ~^ pol_q;
  assign dat_dir = dat_oe ~^ {DW{pol_q}};
endmodule

// File: rtl/sd_bus_power_seq_chk.sv
module sd_bus_power_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ps,
  input logic        drv,
  input logic        pol,
  input logic        ready,
  input logic        bus_sel,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_rdata,
  input logic        cmd_oe,
  input logic        clk_o
);
  AST_ON_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ps == 2'b11 |=> ps == 2'b11); // R5
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready); // R6
  AST_READY_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n) ready |-> ps == 2'b11); // R6
  AST_POL_GUARD: assert property (@(posedge clk) disable iff (!rst_n) ps != 2'b00 |=> $stable(pol)); // R8
  AST_BAD_SIZE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != 2'b10) |=> $stable(bus_rdata)); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[31:5] == 27'd0); // R11
  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == 2'b00 && !drv) |-> (!cmd_oe && !clk_o)); // R1
endmodule

bind sd_bus_power_seq sd_bus_power_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ps(ps_q), .drv(drv_q), .pol(pol_q), .ready(ready),
  .bus_sel(bus_sel), .bus_size(bus_size), .bus_rdata(bus_rdata),
  .cmd_oe(cmd_oe), .clk_o(clk_o)
);

// File: tb/sd_bus_power_seq_tb.sv
module sd_bus_power_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_err, cmd_fsm_en = 0, resp_ok = 0, cclk_tick = 0, card_clk_src = 0;
  logic op_cmd_oe = 0, op_cmd_o = 0;
  logic [7:0] op_dat_oe = 0, op_dat_o = 0;
  logic clk_oe, clk_o, cmd_oe, cmd_o, cmd_dir, clk_run, ready, vsw_start;
  logic [7:0] dat_oe, dat_o, dat_dir;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [1:0] m_ps = 0;
  bit m_drv = 0, m_go = 0, m_stop = 0, m_pol = 0, m_halt = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  sd_bus_power_seq dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] exp_pins();
    logic c_oe, c_o, k_o; logic [7:0] d_oe, d_o;
    c_oe = 0; c_o = 0; d_oe = 0; d_o = 0; k_o = 0;
    case (m_ps)
      2'b00: if (m_drv) begin k_o = 1; c_oe = 1; c_o = 1; d_oe = '1; d_o = '1; end
      2'b10: begin c_oe = 1; d_oe = '1; end
      2'b11: begin
        k_o = card_clk_src & !(m_halt & m_stop);
        if (m_cnt >= 74) begin c_oe = op_cmd_oe; c_o = op_cmd_o; d_oe = op_dat_oe; d_o = op_dat_o; end
        else begin c_oe = 1; c_o = 1; d_oe = '1; d_o = '1; end
      end
      default: ;
    endcase
    return {1'b1, k_o, c_oe, c_o, d_oe, d_o, m_pol ? c_oe : ~c_oe, m_pol ? d_oe : ~d_oe};
  endfunction

  task automatic chk_all(string req);
    chk(req, {clk_oe, clk_o, cmd_oe, cmd_o, dat_oe, dat_o, cmd_dir, dat_dir}, exp_pins());
    chk(req, bus_rdata, {27'd0, m_pol, m_stop, m_go, m_ps});
    chk(req, {ready, clk_run, vsw_start},
        {m_ps == 3 && m_cnt >= 74, m_ps == 3 && !(m_halt && m_stop), m_go});
  endtask

  task automatic wr(logic [31:0] d, logic [1:0] sz, bit tick, bit rsp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_size = sz; bus_wdata = d; cclk_tick = tick; resp_ok = rsp;
    #1 chk("R10", bus_err, sz != 2'b10);
    if (rsp && m_stop && m_ps == 3) m_halt = 1;
    if (tick && m_ps == 3 && m_cnt < 74) m_cnt++;
    if (sz == 2'b10) begin
      if (!cmd_fsm_en) m_stop = d[3];
      if (!m_stop) m_halt = 0;
      m_go = d[2];
      if (m_ps == 0) m_pol = d[4];
      if (m_ps != 3 && d[1:0] != 2'b01) begin m_ps = d[1:0]; m_drv = (d[1:0] == 0); end
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; cclk_tick = 0; resp_ok = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cclk_tick = 1;
      if (m_ps == 3 && m_cnt < 74) m_cnt++;
      @(negedge clk); cclk_tick = 0;
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1");
    wr(32'h1, 2'b10, 0, 0); chk_all("R4");
    wr(32'h0, 2'b10, 0, 0); chk_all("R2");
    wr(32'h1, 2'b10, 0, 0); chk_all("R4");
    wr(32'hFFFF_FFF2, 2'b10, 0, 0); chk_all("R3 R11 R12");
    wr(32'h10, 2'b10, 0, 0); chk_all("R8");
    wr(32'h1, 2'b10, 0, 0); chk_all("R4");
    for (int p = 0; p < 2; p++) begin
      wr(32'h0 | (p << 4), 2'b10, 0, 0); chk_all("R8");
      wr(32'h2, 2'b10, 0, 0); chk_all("R8");
    end
    for (int s = 0; s < 4; s++)
      if (s != 2) begin
        wr(32'h13, s[1:0], 0, 0); chk_all("R10");
      end
    for (int g = 0; g < 4; g++) begin
      wr({29'd0, g[0], 2'b10}, 2'b10, 0, 0); chk_all("R12");
    end
    cmd_fsm_en = 1;
    wr(32'h0A, 2'b10, 0, 0); chk_all("R9");
    cmd_fsm_en = 0;
    wr(32'h0A, 2'b10, 0, 0); chk_all("R9");
    card_clk_src = 1;
    wr(32'h0B, 2'b10, 1, 0); chk_all("R6");
    ticks(73); chk_all("R6");
    wr(32'h08, 2'b10, 0, 0); chk_all("R5");
    ticks(1); chk_all("R6");
    for (int k = 0; k < 8; k++) begin
      op_cmd_oe = k[0]; op_cmd_o = k[1]; op_dat_oe = 8'h5A ^ (k * 8'h21); op_dat_o = 8'hC3 + k[7:0];
      #1 chk_all("R7");
    end
    @(negedge clk); resp_ok = 1; if (m_stop) m_halt = 1;
    @(negedge clk); resp_ok = 0; chk_all("R9");
    cmd_fsm_en = 1;
    wr(32'h03, 2'b10, 0, 1); chk_all("R9");
    cmd_fsm_en = 0;
    wr(32'h03, 2'b10, 0, 1); chk_all("R9");
    for (int v = 0; v < 4; v++) begin
      wr({27'd0, 1'b0, 1'b0, 1'b0, v[1:0]}, 2'b10, 0, 0); chk_all("R5");
    end
    card_clk_src = 0; #1 chk_all("R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule